// File: doc/BRIEF.md
# Per-Destination Indexed Input Queue Controller

This block manages a single input buffer of a cell switch. Every stored cell carries a payload and the output port it is bound for. Cells do not leave in plain FIFO order. An external arbiter names one destination per time slot, and the block releases the oldest stored cell for that destination, wherever it sits in the buffer. Cells bound for the same destination therefore keep their arrival order, while cells bound for different destinations pass each other freely.

For each destination the controller holds three things: a count of queued cells, the index of the oldest of them, and a request bit. The request bits are presented to the arbiter as a vector. A release makes the pointer of the served destination stale. In the following clock cycles a deferred scan walks the buffer one entry per clock, starting just after the freed entry, to find the new oldest cell. The cost of this scan grows with the buffer depth and does not depend on the number of destinations. Each entry stores a rank, which is the number of same-destination cells ahead of it, so the scan can stop at the first match.

Top module: `dest_queue_ctrl`

## Requirements
- R1: After synchronous reset, all request bits, `busy_o`, `cell_vld_o`, `drop_o` and `err_o` are 0, and the buffer holds no cells.
- R2: An accepted arrival for a destination with no queued cells sets request bit d (bit index equals the destination number) in the cycle after the arrival.
- R3: Request bit d stays 1 while any cell for destination d is queued. It returns to 0 in the cycle after the grant that removes the last such cell.
- R4: An accepted grant (`gnt_vld_i` high, `busy_o` low, at least one cell queued for `gnt_dest_i`) raises `cell_vld_o` in the next cycle, with `cell_dest_o` equal to the granted destination.
- R5: For each destination, cells leave in their arrival order. `cell_data_o` carries the payload of the oldest queued cell for the granted destination.
- R6: A grant can release a cell that arrived after cells bound for other destinations, which are still queued.
- R7: After an accepted grant that leaves at least one cell for that destination, `busy_o` is 1 from the next cycle and falls within DEPTH cycles. After a grant that empties its destination, `busy_o` stays 0.
- R8: A grant presented while `busy_o` is 1 is ignored. No cell leaves, and `err_o` pulses in the next cycle.
- R9: A grant for a destination with no queued cells is ignored. No cell leaves, and `err_o` pulses in the next cycle.
- R10: The buffer holds at most DEPTH cells. An arrival while it is full is discarded, and `drop_o` pulses in the next cycle. A discarded cell never leaves.
- R11: An arrival and an accepted grant in the same cycle both take effect, even for the same destination. At most two request bits change per cycle.
- R12: Reset asserted during operation discards every queued cell. A later grant for a previously busy destination is treated as a grant for an empty destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arr_vld_i | input | 1 | An arriving cell is present this cycle |
| arr_dest_i | input | $clog2(NUM_DEST) | Destination of the arriving cell |
| arr_data_i | input | W | Payload of the arriving cell |
| gnt_vld_i | input | 1 | Arbiter grant valid |
| gnt_dest_i | input | $clog2(NUM_DEST) | Destination granted by the arbiter |
| req_o | output | NUM_DEST | Per-destination request bits |
| busy_o | output | 1 | Pointer scan in progress; grants are not accepted |
| cell_vld_o | output | 1 | A released cell is on the outputs |
| cell_dest_o | output | $clog2(NUM_DEST) | Destination of the released cell |
| cell_data_o | output | W | Payload of the released cell |
| drop_o | output | 1 | Pulse: an arrival was discarded because the buffer was full |
| err_o | output | 1 | Pulse: a grant was ignored |

## Verification
The assertions do not assume a well-behaved arbiter. Grants during `busy_o` and grants for empty destinations are legal inputs, and the assertions check that such grants produce an error pulse and no cell. The internal checks do assume that NUM_DEST is a power of two, so every destination code addresses a real counter. The stimulus keeps destination codes inside that range. It deliberately issues grants during scans and for empty destinations, and arrivals into a full buffer. Most random grants target a destination that currently has cells queued, so that the buffer both fills and drains.

// File: rtl/dqc_pkg.sv
package dqc_pkg;
   typedef enum logic {
      SRCH_IDLE = 1'b0,
      SRCH_RUN  = 1'b1
   } srch_state_e;
endpackage

// File: rtl/dqc_free_find.sv
module dqc_free_find #(
   parameter int DEPTH = 16,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DEPTH-1:0]  vld_i,
   output logic [IDX_W-1:0]  free_idx_o,
   output logic              full_o
);
   always_comb begin
      free_idx_o = '0;
      full_o     = 1'b1;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld_i[i]) begin
            free_idx_o = IDX_W'(i);
            full_o     = 1'b0;
         end
      end
   end

   // the chosen slot must really be empty (R10 capacity)
   assert_free_slot_empty_R10: assert property (@(posedge clk) disable iff (rst)
      !full_o |-> !vld_i[free_idx_o]);
endmodule

// File: rtl/dqc_cell_store.sv
module dqc_cell_store #(
   parameter int DEPTH    = 16,
   parameter int NUM_DEST = 8,
   parameter int W        = 8,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int DEST_W  = $clog2(NUM_DEST),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DEST_W-1:0] wr_dest_i,
   input  logic [CNT_W-1:0]  wr_rank_i,
   input  logic [W-1:0]      wr_data_i,
   input  logic              rel_en_i,
   input  logic [IDX_W-1:0]  rel_idx_i,
   input  logic [DEST_W-1:0] rel_dest_i,
   output logic [DEPTH-1:0]  vld_o,
   output logic [DEST_W-1:0] dest_o [DEPTH],
   output logic [CNT_W-1:0]  rank_o [DEPTH],
   output logic [W-1:0]      data_o [DEPTH]
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (rst) begin
            vld_o[i]  <= 1'b0;
            dest_o[i] <= '0;
            rank_o[i] <= '0;
            data_o[i] <= '0;
         end else if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
            vld_o[i]  <= 1'b1;
            dest_o[i] <= wr_dest_i;
            rank_o[i] <= wr_rank_i;
            data_o[i] <= wr_data_i;
         end else if (rel_en_i && rel_idx_i == IDX_W'(i)) begin
            vld_o[i]  <= 1'b0;
         end else if (rel_en_i && vld_o[i] && dest_o[i] == rel_dest_i
                      && rank_o[i] != '0) begin
            rank_o[i] <= rank_o[i] - 1'b1;
         end
      end

      // writes only land on empty entries (R10)
      assert_write_empty_R10: assert property (@(posedge clk) disable iff (rst)
         (wr_en_i && wr_idx_i == IDX_W'(i)) |-> !vld_o[i]);
   end
endmodule

// File: rtl/dqc_dest_table.sv
module dqc_dest_table #(
   parameter int NUM_DEST = 8,
   parameter int DEPTH    = 16,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int DEST_W  = $clog2(NUM_DEST),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                arr_en_i,
   input  logic [DEST_W-1:0]   arr_dest_i,
   input  logic [IDX_W-1:0]    arr_idx_i,
   input  logic                rel_en_i,
   input  logic [DEST_W-1:0]   rel_dest_i,
   input  logic                upd_en_i,
   input  logic [DEST_W-1:0]   upd_dest_i,
   input  logic [IDX_W-1:0]    upd_idx_i,
   output logic [CNT_W-1:0]    cnt_o [NUM_DEST],
   output logic [IDX_W-1:0]    ptr_o [NUM_DEST],
   output logic [NUM_DEST-1:0] req_o
);
   for (genvar d = 0; d < NUM_DEST; d++) begin : g_dst
      logic inc, dec;
      assign inc = arr_en_i && arr_dest_i == DEST_W'(d);
      assign dec = rel_en_i && rel_dest_i == DEST_W'(d);

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_o[d] <= '0;
            ptr_o[d] <= '0;
            req_o[d] <= 1'b0;
         end else begin
            if (inc && !dec)      cnt_o[d] <= cnt_o[d] + 1'b1;
            else if (dec && !inc) cnt_o[d] <= cnt_o[d] - 1'b1;

            if (inc && cnt_o[d] == '0)
               ptr_o[d] <= arr_idx_i;
            else if (upd_en_i && upd_dest_i == DEST_W'(d))
               ptr_o[d] <= upd_idx_i;

            if (inc && cnt_o[d] == '0)
               req_o[d] <= 1'b1;
            else if (dec && !inc && cnt_o[d] == CNT_W'(1))
               req_o[d] <= 1'b0;
         end
      end

      assert_req_tracks_cnt_R3: assert property (@(posedge clk) disable iff (rst)
         req_o[d] == (cnt_o[d] != '0));
      assert_cnt_cap_R10: assert property (@(posedge clk) disable iff (rst)
         cnt_o[d] <= CNT_W'(DEPTH));
   end
endmodule

// File: rtl/dest_queue_ctrl.sv
module dest_queue_ctrl
   import dqc_pkg::*;
#(
   parameter int NUM_DEST = 8,
   parameter int DEPTH    = 16,
   parameter int W        = 8,
   localparam int DEST_W  = $clog2(NUM_DEST),
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                arr_vld_i,
   input  logic [DEST_W-1:0]   arr_dest_i,
   input  logic [W-1:0]        arr_data_i,
   input  logic                gnt_vld_i,
   input  logic [DEST_W-1:0]   gnt_dest_i,
   output logic [NUM_DEST-1:0] req_o,
   output logic                busy_o,
   output logic                cell_vld_o,
   output logic [DEST_W-1:0]   cell_dest_o,
   output logic [W-1:0]        cell_data_o,
   output logic                drop_o,
   output logic                err_o
);
   // elaboration-time parameter checks
   if (NUM_DEST < 2 || (1 << DEST_W) != NUM_DEST) begin : g_bad_dest
      $error("NUM_DEST must be a power of two and at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("W must be at least 1");
   end

   logic [DEPTH-1:0]  ent_vld;
   logic [DEST_W-1:0] ent_dest [DEPTH];
   logic [CNT_W-1:0]  ent_rank [DEPTH];
   logic [W-1:0]      ent_data [DEPTH];
   logic [CNT_W-1:0]  cnt [NUM_DEST];
   logic [IDX_W-1:0]  ptr [NUM_DEST];
   logic [IDX_W-1:0]  free_idx;
   logic              full;

   srch_state_e       state;
   logic [DEST_W-1:0] srch_dest;
   logic [IDX_W-1:0]  srch_idx, srch_steps;

   logic              arr_ok, gnt_ok, same, keep_srch, scan_hit, last_step;
   logic [CNT_W-1:0]  cnt_g, cnt_a, arr_rank;
   logic [IDX_W-1:0]  ptr_g, ptr_g_nx, srch_nx;

   assign busy_o    = (state == SRCH_RUN);
   assign cnt_g     = cnt[gnt_dest_i];
   assign cnt_a     = cnt[arr_dest_i];
   assign ptr_g     = ptr[gnt_dest_i];
   assign arr_ok    = arr_vld_i && !full;
   assign gnt_ok    = gnt_vld_i && !busy_o && cnt_g != '0;
   assign same      = arr_ok && arr_dest_i == gnt_dest_i;
   assign keep_srch = gnt_ok && (cnt_g != CNT_W'(1) || same);
   assign arr_rank  = (gnt_ok && same) ? cnt_a - 1'b1 : cnt_a;
   assign ptr_g_nx  = (ptr_g == IDX_W'(DEPTH - 1)) ? '0 : ptr_g + 1'b1;
   assign srch_nx   = (srch_idx == IDX_W'(DEPTH - 1)) ? '0 : srch_idx + 1'b1;
   assign scan_hit  = ent_vld[srch_idx] && ent_dest[srch_idx] == srch_dest
                      && ent_rank[srch_idx] == '0;
   assign last_step = (srch_steps == IDX_W'(DEPTH - 1));

   dqc_free_find #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_free (
      .clk(clk), .rst(rst), .vld_i(ent_vld),
      .free_idx_o(free_idx), .full_o(full));

   dqc_cell_store #(.DEPTH(DEPTH), .NUM_DEST(NUM_DEST), .W(W)) u_store (
      .clk(clk), .rst(rst),
      .wr_en_i(arr_ok), .wr_idx_i(free_idx), .wr_dest_i(arr_dest_i),
      .wr_rank_i(arr_rank), .wr_data_i(arr_data_i),
      .rel_en_i(gnt_ok), .rel_idx_i(ptr_g), .rel_dest_i(gnt_dest_i),
      .vld_o(ent_vld), .dest_o(ent_dest), .rank_o(ent_rank), .data_o(ent_data));

   dqc_dest_table #(.NUM_DEST(NUM_DEST), .DEPTH(DEPTH)) u_table (
      .clk(clk), .rst(rst),
      .arr_en_i(arr_ok), .arr_dest_i(arr_dest_i), .arr_idx_i(free_idx),
      .rel_en_i(gnt_ok), .rel_dest_i(gnt_dest_i),
      .upd_en_i(busy_o && scan_hit), .upd_dest_i(srch_dest), .upd_idx_i(srch_idx),
      .cnt_o(cnt), .ptr_o(ptr), .req_o(req_o));

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= SRCH_IDLE;
         srch_dest   <= '0;
         srch_idx    <= '0;
         srch_steps  <= '0;
         cell_vld_o  <= 1'b0;
         cell_dest_o <= '0;
         cell_data_o <= '0;
         drop_o      <= 1'b0;
         err_o       <= 1'b0;
      end else begin
         cell_vld_o <= gnt_ok;
         drop_o     <= arr_vld_i && full;
         err_o      <= gnt_vld_i && !gnt_ok;
         if (gnt_ok) begin
            cell_dest_o <= gnt_dest_i;
            cell_data_o <= ent_data[ptr_g];
         end
         case (state)
            SRCH_IDLE: if (keep_srch) begin
               state      <= SRCH_RUN;
               srch_dest  <= gnt_dest_i;
               srch_idx   <= ptr_g_nx;
               srch_steps <= '0;
            end
            SRCH_RUN: begin
               if (scan_hit || last_step) begin
                  state <= SRCH_IDLE;
               end else begin
                  srch_idx   <= srch_nx;
                  srch_steps <= srch_steps + 1'b1;
               end
            end
            default: state <= SRCH_IDLE;
         endcase
      end
   end

   // a settled pointer names the oldest queued cell of its destination
   for (genvar d = 0; d < NUM_DEST; d++) begin : g_chk
      assert_ptr_oldest_R5: assert property (@(posedge clk) disable iff (rst)
         (cnt[d] != '0 && !(busy_o && srch_dest == DEST_W'(d))) |->
         (ent_vld[ptr[d]] && ent_dest[ptr[d]] == DEST_W'(d) && ent_rank[ptr[d]] == '0));
   end

   assert_empty_gnt_err_R9: assert property (@(posedge clk) disable iff (rst)
      (gnt_vld_i && !busy_o && cnt_g == '0) |=> (err_o && !cell_vld_o));
   assert_busy_gnt_err_R8: assert property (@(posedge clk) disable iff (rst)
      (gnt_vld_i && busy_o) |=> (err_o && !cell_vld_o));
   assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
      (arr_vld_i && full) |=> drop_o);
   assert_two_latches_R11: assert property (@(posedge clk) disable iff (rst)
      (arr_vld_i || gnt_vld_i) |=> ($countones(req_o ^ $past(req_o)) <= 2));
   assert_latch_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (!arr_vld_i && !gnt_vld_i) |=> $stable(req_o));
   assert_empty_no_scan_R7: assert property (@(posedge clk) disable iff (rst)
      (gnt_ok && !keep_srch) |=> !busy_o);
endmodule

// File: tb/dest_queue_ctrl_bench.sv
module dest_queue_ctrl_bench;
   localparam int ND = 8;
   localparam int DP = 16;
   localparam int WD = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic arr_vld = 1'b0, gnt_vld = 1'b0;
   logic [2:0] arr_dest = '0, gnt_dest = '0;
   logic [WD-1:0] arr_data = '0;
   logic [ND-1:0] req_o;
   logic busy_o, cell_vld_o, drop_o, err_o;
   logic [2:0] cell_dest_o;
   logic [WD-1:0] cell_data_o;

   dest_queue_ctrl #(.NUM_DEST(ND), .DEPTH(DP), .W(WD)) u_dest_queue_ctrl (
      .clk(clk), .rst(rst),
      .arr_vld_i(arr_vld), .arr_dest_i(arr_dest), .arr_data_i(arr_data),
      .gnt_vld_i(gnt_vld), .gnt_dest_i(gnt_dest),
      .req_o(req_o), .busy_o(busy_o), .cell_vld_o(cell_vld_o),
      .cell_dest_o(cell_dest_o), .cell_data_o(cell_data_o),
      .drop_o(drop_o), .err_o(err_o));

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0, pay = 0;
   bit done = 1'b0;
   int mdata [ND][DP];
   int mcnt  [ND];

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int total();
      int t = 0;
      for (int d = 0; d < ND; d++) t += mcnt[d];
      return t;
   endfunction

   function automatic int exp_req();
      int r = 0;
      for (int d = 0; d < ND; d++) if (mcnt[d] > 0) r |= (1 << d);
      return r;
   endfunction

   task automatic model_clear();
      for (int d = 0; d < ND; d++) mcnt[d] = 0;
   endtask

   // one time slot: drive at negedge, check after the following posedge
   task automatic slot(input bit av, input int ad, input bit gv, input int gd);
      bit bsy, full, aok, gok;
      int exp_d, ap;
      @(negedge clk);
      bsy  = busy_o;
      full = (total() == DP);
      aok  = av && !full;
      gok  = gv && !bsy && mcnt[gd] > 0;
      ap   = pay;
      pay  = (pay + 1) % 256;
      exp_d = 0;
      arr_vld = av; arr_dest = 3'(ad); arr_data = WD'(ap);
      gnt_vld = gv; gnt_dest = 3'(gd);
      if (gok) begin
         exp_d = mdata[gd][0];
         for (int i = 0; i < mcnt[gd] - 1; i++) mdata[gd][i] = mdata[gd][i+1];
         mcnt[gd]--;
      end
      if (aok) begin
         mdata[ad][mcnt[ad]] = ap;
         mcnt[ad]++;
      end
      @(posedge clk);
      #1;
      arr_vld = 1'b0; gnt_vld = 1'b0;
      chk("R4 cell_vld", int'(cell_vld_o), int'(gok));
      if (gok) begin
         chk("R5 order payload", int'(cell_data_o), exp_d);
         chk("R4 cell_dest", int'(cell_dest_o), gd);
         chk("R7 busy after grant", int'(busy_o), int'(mcnt[gd] > 0));
      end
      if (bsy) chk("R8 err", int'(err_o), int'(gv));
      else     chk("R9 err", int'(err_o), int'(gv && !gok));
      chk("R10 drop", int'(drop_o), int'(av && full));
      chk("R3 req", int'(req_o), exp_req());
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy_o && n <= DP + 1) begin
         slot(0, 0, 0, 0);
         n++;
      end
      chk("R7 scan length", int'(n <= DP), 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_clear();
      #1;
   endtask

   int p_mid, p_a, p_b, p_c, d;

   initial begin
      void'($urandom(32'd20240611));
      model_clear();
      do_reset();
      chk("R1 req", int'(req_o), 0);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 cell_vld", int'(cell_vld_o), 0);
      chk("R1 drop", int'(drop_o), 0);
      chk("R1 err", int'(err_o), 0);

      // R2: first arrival sets its request bit
      p_a = pay; slot(1, 3, 0, 0);
      chk("R2 req bit 3", int'(req_o[3]), 1);
      p_mid = pay; slot(1, 5, 0, 0);
      p_b = pay; slot(1, 3, 0, 0);
      p_c = pay; slot(1, 3, 0, 0);
      // R6: the later destination-5 cell leaves ahead of older destination-3 cells
      slot(0, 0, 1, 5);
      chk("R6 middle cell", int'(cell_data_o), p_mid);
      chk("R7 no scan when emptied", int'(busy_o), 0);
      slot(0, 0, 1, 3);
      chk("R5 first of dest 3", int'(cell_data_o), p_a);
      // R8: grant issued while the scan runs
      slot(0, 0, 1, 3);
      chk("R8 no cell while busy", int'(cell_vld_o), 0);
      wait_idle();
      slot(0, 0, 1, 3);
      chk("R5 second of dest 3", int'(cell_data_o), p_b);
      wait_idle();
      // R11: last cell leaves as a new one arrives for the same destination
      p_a = pay; slot(1, 3, 1, 3);
      chk("R11 same-dest swap payload", int'(cell_data_o), p_c);
      chk("R11 req bit 3 held", int'(req_o[3]), 1);
      wait_idle();
      // R11: one bit set and another cleared in the same cycle
      slot(1, 6, 1, 3);
      chk("R11 two bits change", int'(req_o), 32'h40);
      // R9: grant for an empty destination
      slot(0, 0, 1, 0);
      chk("R9 ignored grant", int'(cell_vld_o), 0);

      // R10: fill the buffer, then overflow it
      while (total() < DP) slot(1, int'($urandom % ND), 0, 0);
      slot(1, 2, 0, 0);
      chk("R10 drop on full", int'(drop_o), 1);
      while (total() > 0) begin
         d = int'($urandom % ND);
         while (mcnt[d] == 0) d = (d + 1) % ND;
         slot(0, 0, 1, d);
         wait_idle();
      end
      chk("R10 drained", int'(req_o), 0);

      // R12: reset in the middle of traffic
      slot(1, 4, 0, 0);
      slot(1, 4, 0, 0);
      do_reset();
      chk("R12 req cleared", int'(req_o), 0);
      slot(0, 0, 1, 4);
      chk("R12 stale grant err", int'(err_o), 1);

      // constrained random traffic
      for (int k = 0; k < 4000; k++) begin
         bit av, gv;
         int ad, gd;
         av = ($urandom % 100) < 55;
         gv = ($urandom % 100) < 50;
         ad = int'($urandom % ND);
         gd = int'($urandom % ND);
         if (gv && ($urandom % 100) < 85 && total() > 0)
            while (mcnt[gd] == 0) gd = (gd + 1) % ND;
         slot(av, ad, gv, gd);
      end

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule